// File: doc/BRIEF.md
# Stretched Multiplexed Bus Cycle Sequencer

This block is the master side of a multiplexed external address/data bus. It accepts one request at a time (address, write data, word/byte size, read/write) and turns it into a fixed four-phase bus cycle (phases S0, S1, S2 and S3) on a shared address/data bus. It drives a read/write line, an active-low low-byte strobe, an active-low select, a no-access flag and a bus clock. The system clock runs at four times the bus rate, so each phase normally lasts one system clock. The external memory gives no acknowledge. Slow devices are served by a programmable stretch of 0 to 3 whole bus periods, which is inserted into S2.

The bus has a wide mode (16-bit data, with both byte lanes used) and a narrow mode (8-bit data, on the upper lane only). In narrow mode a word request runs as two byte accesses back to back, and completion is reported once, after the second access. A new request can be taken while the bus is idle or during the last phase of an access. When it is taken in the last phase, accesses follow each other with no idle cycle between them. Read data is captured at the end of S3 and presented on the request side together with a one-cycle completion pulse.

Top module: `ext_bus_seq`

## Requirements
- R1: An accepted access runs S0, S1, S2 and S3. S0, S1 and S3 each last one clock. S2 lasts 1+4*N clocks, where N is the stretch value. `done` rises exactly B*(4+4*N) clocks after the accepting edge, where B is 2 for a narrow-mode word and 1 otherwise. `bus_eclk` is low in S0/S1 and high in S2/S3.
- R2: In S0 the beat address is on `bus_ad_out` with `bus_ad_oe`=1 and `bus_cs_n`=1. `bus_rw` is 1 for a read and 0 for a write. `bus_lstrb_n` is 0 when the beat is a wide-mode word or the beat address has bit 0 set, and is 1 otherwise.
- R3: In S1 `bus_cs_n` goes to 0, while the address, `bus_rw` and `bus_lstrb_n` keep their S0 values.
- R4: `bus_cs_n` stays 0 through S2 and S3. During these phases a write drives data with `bus_ad_oe`=1: a wide word is driven as the full write data, and any byte beat is driven as that byte on both lanes. A read keeps `bus_ad_oe`=0.
- R5: The stretch value and the mode are sampled at the accepting edge and hold for all beats of that request. Later changes have no effect on it.
- R6: Read data is taken from `bus_ad_in` at the end of S3. A wide word gives `{high lane, low lane}` (even byte high). A wide byte at an even address takes the high lane, and at an odd address it takes the low lane. A narrow byte takes the high lane. Bytes are zero-extended into `rdata[7:0]`.
- R7: After S3, `bus_cs_n` and `bus_lstrb_n` return to 1 and `bus_rw` returns to 1. The exception is that `bus_rw` stays 0 with no gap when the next access is a write that starts at once.
- R8: In narrow mode a word request runs two beats: first at the even address (`bus_lstrb_n`=1, upper data byte), then at address+1 (`bus_lstrb_n`=0, lower data byte). Both beats use the upper lane.
- R9: `bus_noacc` is 1 exactly while no access is in progress. In that state `bus_cs_n`=1, `bus_rw`=1, `bus_lstrb_n`=1 and `bus_ad_oe`=0.
- R10: `req_ready` is 1 only when idle, or in S3 with no second narrow beat pending. Bit 0 of the address is ignored for word requests.
- R11: Every request, read or write, produces exactly one single-cycle `done` pulse.
- R12: While `rst` is high the block is idle: `bus_noacc`=1, `bus_cs_n`=1, `bus_rw`=1, `bus_lstrb_n`=1, `bus_ad_oe`=0, `bus_eclk`=0, `done`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, four times the bus rate |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on this edge if valid |
| req_addr | input | DW | Byte address |
| req_wdata | input | DW | Write data; a byte uses bits [7:0] |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| narrow_mode | input | 1 | 1 = 8-bit external data bus |
| stretch | input | SW | Stretch bus periods added to S2 |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Read result, valid with `done` |
| bus_ad_out | output | DW | Multiplexed address/data out |
| bus_ad_oe | output | 1 | Drive enable for `bus_ad_out` |
| bus_ad_in | input | DW | Multiplexed data in |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_lstrb_n | output | 1 | Low-byte strobe, active low |
| bus_cs_n | output | 1 | Select, active low |
| bus_noacc | output | 1 | No access in progress |
| bus_eclk | output | 1 | Bus clock |

## Verification
All bus outputs are registered from the next phase. A phase therefore becomes visible in the clock after the edge that enters it: S0 shows in the cycle right after the accepting edge, and `done` shows B*(4+4*N) edges after that edge. The bench counts edges from acceptance and compares that difference with the value computed from the stretch and the mode it sent. For the per-phase checks, the bench steps one falling edge at a time from the S0 cycle and samples every output away from the rising edge. A bus-side memory model latches the address at the S0 edge and stores write data during S2/S3. Reads are compared against a shadow memory kept at request time.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_S0   = 3'd1,
    PH_S1   = 3'd2,
    PH_S2   = 3'd3,
    PH_S3   = 3'd4
  } phase_t;

  // control bits held for the request in flight
  typedef struct packed {
    logic write;
    logic word;
    logic narrow;
    logic split;   // narrow word: two beats
    logic second;  // second beat running
  } acc_ctl_t;

endpackage

// File: rtl/ebs_phase_fsm.sv
module ebs_phase_fsm
  import ebs_pkg::*;
#(
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          more,
  input  logic [SW-1:0] stretch_n,
  output phase_t        phase_q,
  output phase_t        phase_n,
  output logic          ready,
  output logic          accept
);

  localparam int CW = SW + 2;  // four clocks per stretch period

  logic [CW-1:0] cnt_q;

  always_comb begin
    ready   = (phase_q == PH_IDLE) || ((phase_q == PH_S3) && !more);
    accept  = req_valid && ready;
    phase_n = phase_q;
    case (phase_q)
      PH_IDLE: if (accept) phase_n = PH_S0;
      PH_S0:   phase_n = PH_S1;
      PH_S1:   phase_n = PH_S2;
      PH_S2:   if (cnt_q == '0) phase_n = PH_S3;
      PH_S3:   phase_n = (more || accept) ? PH_S0 : PH_IDLE;
      default: phase_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_n;
      if (phase_n == PH_S0)
        cnt_q <= {stretch_n, 2'b00};
      else if ((phase_q == PH_S2) && (cnt_q != '0))
        cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/ebs_beat_fmt.sv
module ebs_beat_fmt
  import ebs_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] wdata,
  input  acc_ctl_t      ctl,
  output logic [DW-1:0] beat_addr,
  output logic [DW-1:0] lane,
  output logic          lstrb_n
);

  localparam int BW = DW / 2;

  logic          wide_word;
  logic [BW-1:0] byte_val;

  always_comb begin
    wide_word = ctl.word && !ctl.narrow;
    beat_addr = {base[DW-1:1], base[0] | ctl.second};
    if (ctl.narrow && ctl.word)
      byte_val = ctl.second ? wdata[BW-1:0] : wdata[DW-1:BW];
    else
      byte_val = wdata[BW-1:0];
    lane    = wide_word ? wdata : {byte_val, byte_val};
    lstrb_n = !(wide_word || beat_addr[0]);
  end

endmodule

// File: rtl/ebs_rd_capture.sv
module ebs_rd_capture
  import ebs_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe,   // last clock of S3
  input  acc_ctl_t      ctl,
  input  logic          beat_a0,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] rdata,
  output logic          done
);

  localparam int BW = DW / 2;

  logic last_beat;
  assign last_beat = !(ctl.split && !ctl.second);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      done  <= 1'b0;
    end else begin
      done <= strobe && last_beat;
      if (strobe && !ctl.write) begin
        if (ctl.narrow) begin
          if (!ctl.word)
            rdata <= {{BW{1'b0}}, bus_in[DW-1:BW]};
          else if (ctl.second)
            rdata[BW-1:0] <= bus_in[DW-1:BW];
          else
            rdata[DW-1:BW] <= bus_in[DW-1:BW];
        end else if (ctl.word) begin
          rdata <= bus_in;
        end else begin
          rdata <= {{BW{1'b0}}, beat_a0 ? bus_in[BW-1:0] : bus_in[DW-1:BW]};
        end
      end
    end
  end

endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ebs_pkg::*;
#(
  parameter int DW = 16,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_word,
  input  logic          req_write,
  input  logic          narrow_mode,
  input  logic [SW-1:0] stretch,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] bus_ad_out,
  output logic          bus_ad_oe,
  input  logic [DW-1:0] bus_ad_in,
  output logic          bus_rw,
  output logic          bus_lstrb_n,
  output logic          bus_cs_n,
  output logic          bus_noacc,
  output logic          bus_eclk
);

  phase_t        phase_q, phase_n;
  logic          accept, more;
  logic [DW-1:0] base_q, base_n, wdata_q, wdata_n;
  acc_ctl_t      ctl_q, ctl_n;
  logic [SW-1:0] st_q, st_n;
  logic [DW-1:0] beat_addr, lane;
  logic          lstrb_n_n;
  logic          addr_ph, data_ph, in_acc;

  assign more = ctl_q.split && !ctl_q.second;
  assign st_n = accept ? stretch : st_q;

  ebs_phase_fsm #(.SW(SW)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .more      (more),
    .stretch_n (st_n),
    .phase_q   (phase_q),
    .phase_n   (phase_n),
    .ready     (req_ready),
    .accept    (accept)
  );

  // next request context
  always_comb begin
    base_n  = base_q;
    wdata_n = wdata_q;
    ctl_n   = ctl_q;
    if (accept) begin
      base_n       = req_word ? {req_addr[DW-1:1], 1'b0} : req_addr;
      wdata_n      = req_wdata;
      ctl_n.write  = req_write;
      ctl_n.word   = req_word;
      ctl_n.narrow = narrow_mode;
      ctl_n.split  = narrow_mode && req_word;
      ctl_n.second = 1'b0;
    end else if ((phase_q == PH_S3) && more) begin
      ctl_n.second = 1'b1;
    end
  end

  ebs_beat_fmt #(.DW(DW)) u_fmt (
    .base      (base_n),
    .wdata     (wdata_n),
    .ctl       (ctl_n),
    .beat_addr (beat_addr),
    .lane      (lane),
    .lstrb_n   (lstrb_n_n)
  );

  always_comb begin
    in_acc  = (phase_n != PH_IDLE);
    addr_ph = (phase_n == PH_S0) || (phase_n == PH_S1);
    data_ph = (phase_n == PH_S2) || (phase_n == PH_S3);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q      <= '0;
      wdata_q     <= '0;
      ctl_q       <= '0;
      st_q        <= '0;
      bus_ad_out  <= '0;
      bus_ad_oe   <= 1'b0;
      bus_rw      <= 1'b1;
      bus_lstrb_n <= 1'b1;
      bus_cs_n    <= 1'b1;
      bus_noacc   <= 1'b1;
      bus_eclk    <= 1'b0;
    end else begin
      base_q      <= base_n;
      wdata_q     <= wdata_n;
      ctl_q       <= ctl_n;
      st_q        <= st_n;
      bus_noacc   <= !in_acc;
      bus_cs_n    <= !(in_acc && (phase_n != PH_S0));
      bus_eclk    <= data_ph;
      bus_rw      <= !(in_acc && ctl_n.write);
      bus_lstrb_n <= in_acc ? lstrb_n_n : 1'b1;
      bus_ad_oe   <= addr_ph || (data_ph && ctl_n.write);
      if (addr_ph)
        bus_ad_out <= beat_addr;
      else if (data_ph && ctl_n.write)
        bus_ad_out <= lane;
    end
  end

  ebs_rd_capture #(.DW(DW)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .strobe  (phase_q == PH_S3),
    .ctl     (ctl_q),
    .beat_a0 (base_q[0] | ctl_q.second),
    .bus_in  (bus_ad_in),
    .rdata   (rdata),
    .done    (done)
  );

endmodule

// File: rtl/ext_bus_seq_chk.sv
module ext_bus_seq_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic          done,
  input logic [DW-1:0] bus_ad_out,
  input logic          bus_ad_oe,
  input logic          bus_rw,
  input logic          bus_lstrb_n,
  input logic          bus_cs_n,
  input logic          bus_noacc,
  input logic          bus_eclk
);

  // R9: idle bus is fully released
  a_r9_idle_release: assert property (@(posedge clk) disable iff (rst)
    bus_noacc |-> (bus_cs_n && bus_rw && bus_lstrb_n && !bus_eclk && !bus_ad_oe));

  // R1: an access opens with S0 (deselected, low bus clock, address driven)
  a_r1_open_in_s0: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_noacc) |-> (bus_cs_n && !bus_eclk && bus_ad_oe));

  // R3: select falls with address and controls held from S0
  a_r3_select_holds_addr: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_cs_n) |-> ($stable(bus_ad_out) && $stable(bus_rw) &&
                         $stable(bus_lstrb_n) && !bus_eclk && bus_ad_oe));

  // R4: reads leave the bus undriven in the data phases
  a_r4_read_floats: assert property (@(posedge clk) disable iff (rst)
    (!bus_cs_n && bus_eclk && bus_rw) |-> !bus_ad_oe);

  // R10: ready during an access only in its last phase
  a_r10_ready_in_s3: assert property (@(posedge clk) disable iff (rst)
    (req_ready && !bus_noacc) |-> (bus_eclk && !bus_cs_n));

  // R11: completion is a single-cycle pulse
  a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: a select release followed by an access lands in S0
  a_r7_release_to_s0: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_cs_n) && !bus_noacc) |-> !bus_eclk);

endmodule

bind ext_bus_seq ext_bus_seq_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_ready   (req_ready),
  .done        (done),
  .bus_ad_out  (bus_ad_out),
  .bus_ad_oe   (bus_ad_oe),
  .bus_rw      (bus_rw),
  .bus_lstrb_n (bus_lstrb_n),
  .bus_cs_n    (bus_cs_n),
  .bus_noacc   (bus_noacc),
  .bus_eclk    (bus_eclk)
);

// File: tb/ext_bus_seq_tb.sv
module ext_bus_seq_tb;

  localparam int DW = 16;
  localparam int SW = 2;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [DW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_word = 1'b0;
  logic          req_write = 1'b0;
  logic          narrow_mode = 1'b0;
  logic [SW-1:0] stretch = '0;
  logic          done;
  logic [DW-1:0] rdata;
  logic [DW-1:0] bus_ad_out;
  logic          bus_ad_oe;
  logic [DW-1:0] bus_ad_in;
  logic          bus_rw, bus_lstrb_n, bus_cs_n, bus_noacc, bus_eclk;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ext_bus_seq #(.DW(DW), .SW(SW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_word(req_word),
    .req_write(req_write), .narrow_mode(narrow_mode), .stretch(stretch),
    .done(done), .rdata(rdata), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
    .bus_ad_in(bus_ad_in), .bus_rw(bus_rw), .bus_lstrb_n(bus_lstrb_n),
    .bus_cs_n(bus_cs_n), .bus_noacc(bus_noacc), .bus_eclk(bus_eclk)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] seed_byte(input int i);
    return (8'(i) * 8'd7) ^ 8'hA5;
  endfunction

  // bus-side memory model and shadow copy
  logic [7:0]    bmem [256];
  logic [7:0]    shm  [256];
  logic [DW-1:0] lat_addr = '0;
  logic [DW-1:0] log_addr [4];
  logic          log_ls   [4];
  int            log_n = 0;
  logic          log_clr = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (!rst && !bus_noacc && !bus_eclk && bus_cs_n) begin
      lat_addr <= bus_ad_out;
      if (!log_clr && log_n < 4) begin
        log_addr[log_n] = bus_ad_out;
        log_ls[log_n]   = bus_lstrb_n;
        log_n++;
      end
    end
    if (log_clr) log_n = 0;
    if (!rst && !bus_cs_n && bus_eclk && !bus_rw && bus_ad_oe) begin
      if (!bus_lstrb_n && !lat_addr[0]) begin
        bmem[{lat_addr[7:1], 1'b0}] = bus_ad_out[15:8];
        bmem[{lat_addr[7:1], 1'b1}] = bus_ad_out[7:0];
      end else if (lat_addr[0]) begin
        bmem[lat_addr[7:0]] = bus_ad_out[7:0];
      end else begin
        bmem[lat_addr[7:0]] = bus_ad_out[15:8];
      end
    end
  end

  always_comb begin
    if (lat_addr[0]) bus_ad_in = {bmem[lat_addr[7:0]], bmem[lat_addr[7:0]]};
    else             bus_ad_in = {bmem[lat_addr[7:0]], bmem[{lat_addr[7:1], 1'b1}]};
  end

  // expected completions
  int            q_lat [$];
  int            q_acc [$];
  logic          q_rd  [$];
  logic [DW-1:0] q_val [$];
  string         q_tag [$];
  string         q_ltag[$];

  always @(negedge clk) begin
    if (!rst && done) begin
      if (q_lat.size() == 0 || q_acc.size() == 0) begin
        chk(1'b0, "R11 done without request", 32'd1, 32'd0);
      end else begin
        int lat, acc;
        logic rd;
        logic [DW-1:0] v;
        string t, lt;
        lat = q_lat.pop_front(); acc = q_acc.pop_front();
        rd = q_rd.pop_front(); v = q_val.pop_front();
        t = q_tag.pop_front(); lt = q_ltag.pop_front();
        chk((cyc - acc) == lat, lt, 32'(cyc - acc), 32'(lat));
        if (rd) chk(rdata == v, t, 32'(rdata), 32'(v));
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic send(input logic [DW-1:0] a, input logic [DW-1:0] wd, input logic w,
                      input logic wr, input logic nar, input logic [SW-1:0] st,
                      input string tag, input string ltag);
    int beats;
    logic [7:0] ai;
    logic [DW-1:0] ev;
    ai = a[7:0];
    beats = (nar && w) ? 2 : 1;
    ev = '0;
    if (wr) begin
      if (w) begin
        shm[{ai[7:1], 1'b0}] = wd[15:8];
        shm[{ai[7:1], 1'b1}] = wd[7:0];
      end else begin
        shm[ai] = wd[7:0];
      end
    end else begin
      ev = w ? {shm[{ai[7:1], 1'b0}], shm[{ai[7:1], 1'b1}]} : {8'h00, shm[ai]};
    end
    q_lat.push_back(beats * (4 + 4 * int'(st)));
    q_rd.push_back(!wr); q_val.push_back(ev);
    q_tag.push_back(tag); q_ltag.push_back(ltag);
    req_addr = a; req_wdata = wd; req_word = w; req_write = wr;
    narrow_mode = nar; stretch = st; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    q_acc.push_back(cyc);
    req_valid = 1'b0;
  endtask

  // cs, rw, lstrb, eclk, oe, noacc, ready
  task automatic look(input string tag, input logic [6:0] exp);
    logic [6:0] act;
    act = {bus_cs_n, bus_rw, bus_lstrb_n, bus_eclk, bus_ad_oe, bus_noacc, req_ready};
    chk(act == exp, tag, 32'(act), 32'(exp));
  endtask

  int rw_hi = 0;
  logic watch_rw = 1'b0;
  always @(negedge clk) if (watch_rw && bus_rw) rw_hi++;

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) begin
      bmem[i] = seed_byte(i);
      shm[i]  = seed_byte(i);
    end
    repeat (3) @(negedge clk);
    look("R12 reset outputs", 7'b1110011);
    chk(done == 1'b0, "R12 reset done", 32'(done), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    look("R9 idle after reset", 7'b1110011);

    // wide byte write at odd address, stretch 1
    send(16'h0013, 16'h00C3, 1'b0, 1'b1, 1'b0, 2'd1, "R6", "R1 write latency");
    look("R2 S0 write odd byte", 7'b1000100);
    chk(bus_ad_out == 16'h0013, "R2 S0 address", 32'(bus_ad_out), 32'h13);
    @(negedge clk);
    look("R3 S1 select", 7'b0000100);
    chk(bus_ad_out == 16'h0013, "R3 S1 address", 32'(bus_ad_out), 32'h13);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      look("R4 S2 stretched write", 7'b0001100);
      chk(bus_ad_out == 16'hC3C3, "R4 S2 byte lanes", 32'(bus_ad_out), 32'hC3C3);
    end
    @(negedge clk);
    look("R10 S3 ready", 7'b0001101);
    @(negedge clk);
    look("R7 release after S3", 7'b1110011);

    // wide even byte read, stretch 0
    send(16'h0020, 16'h0, 1'b0, 1'b0, 1'b0, 2'd0, "R6 even byte", "R1 read latency");
    look("R2 S0 read even byte", 7'b1110100);
    @(negedge clk);
    @(negedge clk);
    look("R4 S2 read floats", 7'b0111000);
    repeat (3) @(negedge clk);

    // stretch changed after acceptance
    send(16'h0031, 16'h0, 1'b0, 1'b0, 1'b0, 2'd0, "R6 odd byte", "R5 stretch sampled");
    stretch = 2'd3;
    narrow_mode = 1'b1;
    repeat (6) @(negedge clk);

    // narrow word read, odd address bit ignored
    log_clr = 1'b1; @(negedge clk); log_clr = 1'b0;
    send(16'h0041, 16'h0, 1'b1, 1'b0, 1'b1, 2'd0, "R8 narrow word read", "R8 two beat latency");
    repeat (10) @(negedge clk);
    chk(log_n == 2, "R8 beat count", 32'(log_n), 32'd2);
    chk(log_addr[0] == 16'h0040, "R8 first beat even", 32'(log_addr[0]), 32'h40);
    chk(log_addr[1] == 16'h0041, "R8 second beat odd", 32'(log_addr[1]), 32'h41);
    chk({log_ls[0], log_ls[1]} == 2'b10, "R8 strobe per beat", 32'({log_ls[0], log_ls[1]}), 32'b10);

    // narrow word write then wide word read back, odd address ignored
    send(16'h0080, 16'hBEEF, 1'b1, 1'b1, 1'b1, 2'd2, "R8", "R8 narrow write latency");
    send(16'h0081, 16'h0, 1'b1, 1'b0, 1'b0, 2'd0, "R10 word addr bit0", "R1 back to back");
    repeat (8) @(negedge clk);

    // back-to-back writes keep rw low
    rw_hi = 0;
    send(16'h0090, 16'h1234, 1'b1, 1'b1, 1'b0, 2'd0, "R7", "R1 b2b write 1");
    watch_rw = 1'b1;
    send(16'h0092, 16'h5678, 1'b1, 1'b1, 1'b0, 2'd0, "R7", "R1 b2b write 2");
    repeat (3) @(negedge clk);
    watch_rw = 1'b0;
    chk(rw_hi == 0, "R7 rw held low between writes", 32'(rw_hi), 32'd0);
    send(16'h0090, 16'h0, 1'b1, 1'b0, 1'b0, 2'd0, "R7 read after write", "R1 read after write");
    chk(bus_rw == 1'b1, "R7 rw high for next read", 32'(bus_rw), 32'd1);
    repeat (6) @(negedge clk);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [DW-1:0] a, wd;
      logic w, wr, nar;
      logic [SW-1:0] st;
      a = 16'($urandom); wd = 16'($urandom);
      w = 1'($urandom); wr = 1'($urandom); nar = 1'($urandom);
      st = SW'($urandom);
      send(a, wd, w, wr, nar, st, "R6 random read", "R1 random latency");
      if (($urandom % 4) == 0) repeat (1 + ($urandom % 12)) @(negedge clk);
    end

    while (q_acc.size() < q_lat.size() || q_lat.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(q_lat.size() == 0, "R11 all requests completed", 32'(q_lat.size()), 32'd0);
    look("R9 idle at end", 7'b1110011);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule